// File: doc/BRIEF.md
# FFT Bin Reorder Buffer

This block sits after a 4096-point FFT whose results leave in a strided order. In that order, natural bin k shows up at stream position 64·k. The block collects each frame and plays it back in natural bin order, so that downstream logic sees bins 0, 1, 2, … 4095 in sequence. The data words are opaque and pass through bit-exact. Only their order changes, and that change is a pure rearrangement of the index bits.

Storage is two banks. Incoming samples are written into one bank at a permuted address while the other bank is read at sequential addresses. A bank becomes readable once its frame is closed. A static select input picks one of two index permutations:
- a 64×64 transpose, which exchanges the upper and lower halves of the 12-bit position;
- a radix-4 digit reversal, which reverses the order of the six 2-bit digits of the position.

Both sides use valid/ready streaming with an end-of-frame marker.

Write-side states:
- `W_FILL`: accepting samples.
- `W_STALL`: both banks are held and the input is back-pressured.
- Transitions: `W_FILL`→`W_STALL` on a frame close while the other bank is still full. `W_STALL`→`W_FILL` once the target bank has been released.

Read-side states:
- `R_IDLE`: no full bank.
- `R_DRAIN`: streaming a bank out.
- Transitions: `R_IDLE`→`R_DRAIN` when the current read bank is full. `R_DRAIN`→`R_IDLE` after the last word of a bank is issued and the other bank is not full. If the other bank is full at that point, the read side stays in `R_DRAIN` on the next bank.

Top module: `fft_bin_reorder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: With `perm_sel`=0 the sample accepted at stream position p (counted from 0 within its frame) appears at output position {p[5:0], p[11:6]}. Position 64·k therefore emerges as output k; output 1 carries position 64.
- R3: With `perm_sel`=1 the sample at position p appears at output position formed by reversing the order of the six 2-bit digits of p. Output 1 therefore carries position 1024.
- R4: In both modes position 0 is emitted first in its frame.
- R5: Every data bit passes unchanged from input to output.
- R6: `out_last` is 1 on natural output index 4095 of each frame and 0 on every other output beat.
- R7: A frame closes when `in_last` is accepted or when the 4096th sample is accepted, whichever comes first. A full frame sent without `in_last` is still emitted completely and the input stays ready for the next frame.
- R8: When both banks hold unread frames, `in_ready` is 0 and no input is accepted. Frames accepted before the stall are all emitted intact after it.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| perm_sel | input | 1 | Permutation select: 0 transpose, 1 radix-4 digit reversal; change only between frames |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input can be accepted |
| in_data | input | DATA_W | Input sample word |
| in_last | input | 1 | Final sample of the input frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | DATA_W | Output word in natural bin order |
| out_last | output | 1 | Natural bin 4095 of the frame |

## Verification
The hardest condition to reach is the write side parked in `W_STALL`. This needs both banks full while the read side is frozen mid-bank with one word waiting in the output register. The stimulus holds `out_ready` low while two complete frames go in. It then offers a third frame and confirms that nothing is taken and the pending output word stays frozen. Only after that is `out_ready` released, with an irregular pattern, so all three frames must drain in order without loss. A frame sent without its end marker separately exercises the count-based close.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
    localparam int NBANKS = 2;

    typedef enum logic {
        W_FILL  = 1'b0,
        W_STALL = 1'b1
    } wr_state_t;

    typedef enum logic {
        R_IDLE  = 1'b0,
        R_DRAIN = 1'b1
    } rd_state_t;
endpackage

// File: rtl/fbr_addr_perm.sv
module fbr_addr_perm #(
    parameter int IDX_W = 12
) (
    input  logic [IDX_W-1:0] pos,
    input  logic             mode,
    output logic [IDX_W-1:0] bin
);
    localparam int HALF   = IDX_W / 2;
    localparam int DIGITS = IDX_W / 2;

    logic [IDX_W-1:0] swapped;
    logic [IDX_W-1:0] reversed;

    assign swapped = {pos[HALF-1:0], pos[IDX_W-1:HALF]};

    generate
        for (genvar d = 0; d < DIGITS; d++) begin : g_digit
            assign reversed[2*d +: 2] = pos[IDX_W-2-2*d +: 2];
        end
    endgenerate

    assign bin = mode ? reversed : swapped;
endmodule

// File: rtl/fbr_wr_ctrl.sv
module fbr_wr_ctrl
    import fbr_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [1:0]       bank_full,
    output logic             in_ready,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_bank,
    output logic             wr_close
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    wr_state_t state, state_n;

    always_ff @(posedge clk) begin
        if (rst) state <= W_FILL;
        else     state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            W_FILL:  if (wr_close && bank_full[~wr_bank]) state_n = W_STALL;
            W_STALL: if (!bank_full[wr_bank])             state_n = W_FILL;
            default: state_n = W_FILL;
        endcase
    end

    always_comb begin
        in_ready = (state == W_FILL);
        wr_en    = in_valid && in_ready;
        wr_close = wr_en && (in_last || wr_idx == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx  <= '0;
            wr_bank <= 1'b0;
        end else if (wr_en) begin
            if (wr_close) begin
                wr_idx  <= '0;
                wr_bank <= ~wr_bank;
            end else begin
                wr_idx <= wr_idx + 1'b1;
            end
        end
    end

    // R8: the writer only offers to accept when its target bank is free
    a_r8_ready_needs_room: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !bank_full[wr_bank]);
endmodule

// File: rtl/fbr_rd_ctrl.sv
module fbr_rd_ctrl
    import fbr_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bank_full,
    input  logic             out_ready,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_idx,
    output logic             rd_bank,
    output logic             rd_release,
    output logic             out_valid,
    output logic             out_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    rd_state_t state, state_n;
    logic      slot_free;

    always_ff @(posedge clk) begin
        if (rst) state <= R_IDLE;
        else     state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            R_IDLE:  if (bank_full[rd_bank])                       state_n = R_DRAIN;
            R_DRAIN: if (rd_release && !bank_full[~rd_bank])       state_n = R_IDLE;
            default: state_n = R_IDLE;
        endcase
    end

    always_comb begin
        slot_free  = !out_valid || out_ready;
        rd_en      = (state == R_DRAIN) && slot_free;
        rd_release = rd_en && (rd_idx == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx    <= '0;
            rd_bank   <= 1'b0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            if (rd_en) begin
                out_valid <= 1'b1;
                out_last  <= (rd_idx == LAST_IDX);
                rd_idx    <= rd_idx + 1'b1;
                if (rd_release) rd_bank <= ~rd_bank;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R9: a word that is not taken stays put
    a_r9_hold_valid: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_last)));
endmodule

// File: rtl/fbr_bank_store.sv
module fbr_bank_store
    import fbr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 12
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_bank,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] bank_word [NBANKS];

    generate
        for (genvar b = 0; b < NBANKS; b++) begin : g_bank
            logic [DATA_W-1:0] mem [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_en && (wr_bank == b[0])) mem[wr_addr] <= wr_data;
            end

            assign bank_word[b] = mem[rd_addr];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= bank_word[rd_bank];
    end
endmodule

// File: rtl/fft_bin_reorder.sv
module fft_bin_reorder
    import fbr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              perm_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    logic [1:0]       bank_full;
    logic [1:0]       set_v, clr_v;
    logic             wr_en, wr_bank, wr_close;
    logic [IDX_W-1:0] wr_idx, wr_addr;
    logic             rd_en, rd_bank, rd_release;
    logic [IDX_W-1:0] rd_idx;

    fbr_wr_ctrl #(.IDX_W(IDX_W)) u_wr (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .bank_full(bank_full), .in_ready(in_ready), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_bank(wr_bank), .wr_close(wr_close)
    );

    fbr_addr_perm #(.IDX_W(IDX_W)) u_perm (
        .pos(wr_idx), .mode(perm_sel), .bin(wr_addr)
    );

    fbr_rd_ctrl #(.IDX_W(IDX_W)) u_rd (
        .clk(clk), .rst(rst), .bank_full(bank_full), .out_ready(out_ready),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_bank(rd_bank),
        .rd_release(rd_release), .out_valid(out_valid), .out_last(out_last)
    );

    fbr_bank_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .wr_data(in_data), .rd_en(rd_en), .rd_bank(rd_bank),
        .rd_addr(rd_idx), .rd_data(out_data)
    );

    always_comb begin
        set_v = wr_close   ? (2'b01 << wr_bank) : 2'b00;
        clr_v = rd_release ? (2'b01 << rd_bank) : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) bank_full <= 2'b00;
        else     bank_full <= (bank_full | set_v) & ~clr_v;
    end

    // Checker state: beats delivered within the current output frame
    logic [IDX_W-1:0] out_beat;
    always_ff @(posedge clk) begin
        if (rst)                        out_beat <= '0;
        else if (out_valid && out_ready) out_beat <= out_beat + 1'b1;
    end

    // R1: the cycle after reset shows no output
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    // R4: position 0 lands on bin 0 in either mode
    a_r4_origin_fixed: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == '0) |-> (wr_addr == '0));

    // R6: the end marker coincides with the final beat of a frame
    a_r6_last_on_final_beat: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |-> (out_last == (out_beat == LAST_IDX)));

    // R9: stalled output data does not change
    a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_data));

    // R8: a frame never closes into a bank that is still held
    a_r8_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !bank_full[wr_bank]);
endmodule

// File: tb/fft_bin_reorder_tb_top.sv
module fft_bin_reorder_tb_top;
    localparam int CLK_P    = 10;
    localparam int DATA_W   = 64;
    localparam int IDX_W    = 12;
    localparam int N        = 1 << IDX_W;
    localparam int HALF     = IDX_W / 2;
    localparam int WD_LIMIT = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              perm_sel = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [DATA_W-1:0] out_data;
    logic              out_last;

    int checks = 0;
    int fails  = 0;
    int frames_done = 0;
    int accepted = 0;
    int rdy_mode = 0;
    int cyc = 0;

    logic [DATA_W:0] exp_q[$];
    string           tag_q[$];
    bit              mode_q[$];

    always #(CLK_P/2) clk = ~clk;

    fft_bin_reorder #(.DATA_W(DATA_W), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst(rst), .perm_sel(perm_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    function automatic int bin_of(input int p, input bit digrev);
        int r = 0;
        if (!digrev) begin
            r = ((p & ((1 << HALF) - 1)) << HALF) | (p >> HALF);
        end else begin
            for (int d = 0; d < IDX_W / 2; d++)
                r |= ((p >> (2 * d)) & 3) << (IDX_W - 2 - 2 * d);
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] word_of(input int frame, input int p);
        return {16'hC3A5 ^ 16'(frame), 16'(frame), 32'(p)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic send_frame(input int frame, input bit digrev, input bit use_last, input string tag);
        logic [DATA_W-1:0] e [N];
        for (int p = 0; p < N; p++) e[bin_of(p, digrev)] = word_of(frame, p);
        for (int k = 0; k < N; k++) exp_q.push_back({(k == N - 1), e[k]});
        tag_q.push_back(tag);
        mode_q.push_back(digrev);
        for (int p = 0; p < N; p++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = word_of(frame, p);
            in_last  = use_last && (p == N - 1);
            #(CLK_P/2 - 1);
            while (!in_ready) begin
                @(negedge clk);
                #(CLK_P/2 - 1);
            end
            accepted++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        while (frames_done < n) @(negedge clk);
    endtask

    // out_ready pattern driver
    initial forever begin
        @(negedge clk);
        cyc++;
        case (rdy_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = 1'b0;
            default: out_ready = (cyc % 3 != 0);
        endcase
    end

    // Scoreboard monitor
    initial begin
        int beat = 0;
        int data_err = 0, hi_err = 0, last_err = 0;
        logic [DATA_W-1:0] bad_act = '0, bad_exp = '0;
        bit cur_mode;
        logic [DATA_W:0] item;
        forever begin
            @(negedge clk);
            #(CLK_P/2 - 1);
            if (!rst && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected output beat", out_data, '0);
                end else begin
                    item = exp_q.pop_front();
                    cur_mode = mode_q[0];
                    if (out_data !== item[DATA_W-1:0]) begin
                        if (data_err == 0) begin
                            bad_act = out_data;
                            bad_exp = item[DATA_W-1:0];
                        end
                        data_err++;
                    end
                    if (out_data[63:32] !== item[63:32]) hi_err++;
                    if (out_last !== item[DATA_W]) last_err++;
                    if (beat == 0)
                        chk(out_data[31:0] == 32'd0, "R4", "first output carries position 0",
                            64'(out_data[31:0]), 64'd0);
                    if (beat == 1) begin
                        if (cur_mode)
                            chk(out_data[31:0] == 32'd1024, "R3", "output 1 carries position 1024",
                                64'(out_data[31:0]), 64'd1024);
                        else
                            chk(out_data[31:0] == 32'd64, "R2", "output 1 carries position 64",
                                64'(out_data[31:0]), 64'd64);
                    end
                    beat++;
                    if (beat == N) begin
                        chk(data_err == 0, tag_q[0], $sformatf("frame %0d order, %0d bad beats", frames_done, data_err),
                            bad_act, bad_exp);
                        chk(hi_err == 0, "R5", $sformatf("frame %0d upper bits", frames_done),
                            64'(hi_err), 64'd0);
                        chk(last_err == 0, "R6", $sformatf("frame %0d last placement", frames_done),
                            64'(last_err), 64'd0);
                        void'(tag_q.pop_front());
                        void'(mode_q.pop_front());
                        beat = 0; data_err = 0; hi_err = 0; last_err = 0;
                        frames_done++;
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 64'(frames_done), 64'd6);
        report();
    end

    // Main sequence
    initial begin
        int acc_before;
        logic [DATA_W-1:0] held;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

        perm_sel = 1'b0;
        send_frame(0, 1'b0, 1'b1, "R2");
        wait_frames(1);

        perm_sel = 1'b1;
        send_frame(1, 1'b1, 1'b1, "R3");
        wait_frames(2);

        perm_sel = 1'b0;
        send_frame(2, 1'b0, 1'b0, "R7");
        wait_frames(3);
        #1;
        chk(in_ready == 1'b1, "R7", "input ready after frame without end marker", 64'(in_ready), 64'd1);

        // Fill both banks with the output stalled
        rdy_mode = 1;
        send_frame(3, 1'b0, 1'b1, "R8");
        send_frame(4, 1'b0, 1'b1, "R8");
        acc_before = accepted;
        fork
            send_frame(5, 1'b0, 1'b1, "R8");
        join_none
        repeat (100) @(negedge clk);
        #(CLK_P/2 - 1);
        chk(in_ready == 1'b0, "R8", "in_ready with both banks full", 64'(in_ready), 64'd0);
        chk(accepted == acc_before, "R8", "samples accepted while full",
            64'(accepted - acc_before), 64'd0);
        chk(out_valid == 1'b1, "R9", "pending word presented", 64'(out_valid), 64'd1);
        held = out_data;
        repeat (20) @(negedge clk);
        #(CLK_P/2 - 1);
        chk(out_data == held, "R9", "stalled data held", out_data, held);
        chk(out_valid == 1'b1 && out_last == 1'b0, "R9", "stalled valid/last held",
            64'({out_valid, out_last}), 64'b10);

        rdy_mode = 2;
        wait fork;
        wait_frames(6);
        chk(exp_q.size() == 0, "R8", "scoreboard drained", 64'(exp_q.size()), 64'd0);
        report();
    end
endmodule